// File: doc/BRIEF.md
# Asynchronous-Assert, Clocked-Release Reset Synchronizer

This block takes an asynchronous request line, usually a board-level reset, and produces a reset that one clock domain can use. The output turns on the moment the request turns on, with no clock needed. It turns off only after a fixed number of clock edges in the destination domain, so every flop it drives leaves reset on the same edge.

A parameter selects the request polarity: the request is active either when the line is high or when it is low. The output is active high in both cases.

A second parameter sets the depth of the flip-flop chain. The default depth is two. Elaboration stops with an error for a depth of zero or less, which is an illegal count, and for a depth of one, which is too shallow to be safe. It also stops for any polarity code other than the two defined ones.

When the design powers up, the output is already on, even if the request is off. It then turns off after the same number of edges as any other release.

Top module: `arst_sync`

## Requirements
- R1: With ACT_EDGE=0 the request is active while `async_i` is 1, and `sync_o` becomes 1 within the same clock period, with no clock edge, when `async_i` rises.
- R2: With ACT_EDGE=1 the request is active while `async_i` is 0, and `sync_o` (still active high) becomes 1 with no clock edge when `async_i` falls.
- R3: `sync_o` stays 1 across every clock edge for as long as the request stays active.
- R4: After the request is released, `sync_o` stays 1 through the first STAGES-1 rising edges and falls on rising edge number STAGES. With the default STAGES=2 it falls on the second edge.
- R5: With STAGES=3, `sync_o` stays 1 through two edges after release and falls on the third.
- R6: At power-on `sync_o` is 1 even though the request is inactive. It falls on rising edge number STAGES.
- R7: A request pulse that begins and ends between two clock edges still drives `sync_o` to 1, and `sync_o` stays 1 until edge number STAGES after the pulse ends.
- R8: While the request stays inactive and the chain is released, `sync_o` stays 0 over any number of clock edges and never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock of the destination domain |
| async_i | input | 1 | Asynchronous request; its active level is set by ACT_EDGE |
| sync_o | output | 1 | Synchronized output, active high, driven straight from the last flop |

## Verification
A rise of `sync_o` is due in the same period as the request, so the bench reads it 1 ns after changing the input, with no clock edge in between. A fall is due on edge number STAGES after release. The bench changes inputs 5 ns after a rising edge and reads outputs 5 ns after each following rising edge, counting edges one by one. Three instances run side by side, each checked against its own count: depth 2 active-high, depth 3 active-high, and depth 2 active-low.

// File: rtl/arst_sync_pkg.sv
`timescale 1ns/1ps
package arst_sync_pkg;
    // Polarity codes for the ACT_EDGE parameter
    localparam int EDGE_RISE = 0;   // request active while the line is high
    localparam int EDGE_FALL = 1;   // request active while the line is low

    localparam int MIN_STAGES = 2;

    function automatic logic to_active(input int edge_sel, input logic raw);
        return (edge_sel == EDGE_FALL) ? ~raw : raw;
    endfunction
endpackage

// File: rtl/arst_sync_pol.sv
`timescale 1ns/1ps
module arst_sync_pol #(
    parameter int ACT_EDGE = arst_sync_pkg::EDGE_RISE
) (
    input  logic raw_i,
    output logic act_o
);
    generate
        if (ACT_EDGE == arst_sync_pkg::EDGE_FALL) begin : g_low
            assign act_o = ~raw_i;
        end else begin : g_high
            assign act_o = raw_i;
        end
    endgenerate
endmodule

// File: rtl/arst_sync_chain.sv
`timescale 1ns/1ps
module arst_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic act_i,
    output logic out_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } chain_t;

    // All flops come up asserted, so power-on behaves like a release
    chain_t chain_q = '1;
    chain_t chain_d;

    always_comb begin
        chain_d    = chain_q;
        chain_d.sh = {chain_q.sh[STAGES-2:0], 1'b0};
    end

    always_ff @(posedge clk_i or posedge act_i) begin
        if (act_i) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign out_o = chain_q.sh[STAGES-1];
endmodule

// File: rtl/arst_sync.sv
`timescale 1ns/1ps
module arst_sync #(
    parameter int STAGES   = 2,
    parameter int ACT_EDGE = arst_sync_pkg::EDGE_RISE
) (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);
    generate
        if (STAGES < 1) begin : g_bad_count
            $error("arst_sync: STAGES=%0d is not a legal stage count", STAGES);
        end else if (STAGES < arst_sync_pkg::MIN_STAGES) begin : g_too_short
            $error("arst_sync: STAGES=%0d is below the safe minimum of 2", STAGES);
        end
        if (ACT_EDGE != arst_sync_pkg::EDGE_RISE &&
            ACT_EDGE != arst_sync_pkg::EDGE_FALL) begin : g_bad_edge
            $error("arst_sync: ACT_EDGE=%0d must be 0 (high) or 1 (low)", ACT_EDGE);
        end
    endgenerate

    logic act;

    arst_sync_pol #(.ACT_EDGE(ACT_EDGE)) u_pol (
        .raw_i (async_i),
        .act_o (act)
    );

    arst_sync_chain #(.STAGES(STAGES)) u_chain (
        .clk_i (clk_i),
        .act_i (act),
        .out_o (sync_o)
    );
endmodule

// File: rtl/arst_sync_chk.sv
`timescale 1ns/1ps
module arst_sync_chk #(
    parameter int STAGES   = 2,
    parameter int ACT_EDGE = 0
) (
    input logic clk_i,
    input logic async_i,
    input logic sync_o
);
    localparam int CW = $clog2(STAGES + 1);
    localparam logic [CW-1:0] LIM = CW'(STAGES);

    logic act;
    assign act = arst_sync_pkg::to_active(ACT_EDGE, async_i);

    // Edges seen since the request was last active (saturating)
    logic [CW-1:0] since_q = '0;
    // Set when the request was active at any time since the last edge
    logic          hit_q   = 1'b1;

    always_ff @(posedge clk_i or posedge act) begin
        if (act) begin
            since_q <= '0;
            hit_q   <= 1'b1;
        end else begin
            hit_q <= 1'b0;
            if (since_q < LIM) since_q <= since_q + 1'b1;
        end
    end

    AST_HOLD_ACTIVE: assert property (@(negedge clk_i)
        act |-> sync_o);                                            // R3

    AST_RISE_CAUSED: assert property (@(posedge clk_i) disable iff (act)
        $rose(sync_o) |-> hit_q);                                   // R8

    AST_RELEASE_LATE: assert property (@(posedge clk_i) disable iff (act)
        (since_q < LIM) |-> sync_o);                                // R4

    AST_RELEASE_DUE: assert property (@(posedge clk_i) disable iff (act)
        (since_q == LIM && !hit_q) |-> !sync_o);                    // R4
endmodule

bind arst_sync arst_sync_chk #(.STAGES(STAGES), .ACT_EDGE(ACT_EDGE)) u_chk (
    .clk_i   (clk_i),
    .async_i (async_i),
    .sync_o  (sync_o)
);

// File: tb/arst_sync_tb.sv
`timescale 1ns/1ps
module arst_sync_tb;
    logic clk = 1'b0;
    logic a_in = 1'b0;   // drives the two active-high instances
    logic n_in = 1'b1;   // drives the active-low instance
    logic o2, o3, on;
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    arst_sync #(.STAGES(2), .ACT_EDGE(0)) u_dut  (.clk_i(clk), .async_i(a_in), .sync_o(o2));
    arst_sync #(.STAGES(3), .ACT_EDGE(0)) u_dut3 (.clk_i(clk), .async_i(a_in), .sync_o(o3));
    arst_sync #(.STAGES(2), .ACT_EDGE(1)) u_dutn (.clk_i(clk), .async_i(n_in), .sync_o(on));

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic t_power_on();
        #1;
        chk(o2, 1'b1, "R6", "depth2 at power-on");
        chk(o3, 1'b1, "R6", "depth3 at power-on");
        chk(on, 1'b1, "R6", "active-low at power-on");
        tick();
        chk(o2, 1'b1, "R6", "depth2 after edge 1");
        chk(o3, 1'b1, "R6", "depth3 after edge 1");
        tick();
        chk(o2, 1'b0, "R6", "depth2 after edge 2");
        chk(on, 1'b0, "R6", "active-low after edge 2");
        chk(o3, 1'b1, "R6", "depth3 after edge 2");
        tick();
        chk(o3, 1'b0, "R6", "depth3 after edge 3");
    endtask

    task automatic t_quiet();
        for (int i = 0; i < 12; i++) begin
            tick();
            chk(o2, 1'b0, "R8", "depth2 idle");
            chk(o3, 1'b0, "R8", "depth3 idle");
            chk(on, 1'b0, "R8", "active-low idle");
        end
    endtask

    task automatic t_rise_high();
        a_in = 1'b1;
        #1;
        chk(o2, 1'b1, "R1", "depth2 asserts without edge");
        chk(o3, 1'b1, "R1", "depth3 asserts without edge");
        chk(on, 1'b0, "R8", "active-low unaffected");
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(o2, 1'b1, "R3", "depth2 held while active");
            chk(o3, 1'b1, "R3", "depth3 held while active");
        end
        a_in = 1'b0;
        #1;
        chk(o2, 1'b1, "R4", "depth2 right after release");
        tick();
        chk(o2, 1'b1, "R4", "depth2 after release edge 1");
        chk(o3, 1'b1, "R5", "depth3 after release edge 1");
        tick();
        chk(o2, 1'b0, "R4", "depth2 after release edge 2");
        chk(o3, 1'b1, "R5", "depth3 after release edge 2");
        tick();
        chk(o3, 1'b0, "R5", "depth3 after release edge 3");
    endtask

    task automatic t_fall_low();
        n_in = 1'b0;
        #1;
        chk(on, 1'b1, "R2", "active-low asserts without edge");
        chk(o2, 1'b0, "R8", "depth2 unaffected");
        tick();
        chk(on, 1'b1, "R3", "active-low held while active");
        tick();
        chk(on, 1'b1, "R3", "active-low held while active");
        n_in = 1'b1;
        tick();
        chk(on, 1'b1, "R2", "active-low after release edge 1");
        tick();
        chk(on, 1'b0, "R2", "active-low after release edge 2");
    endtask

    task automatic t_short_pulse();
        a_in = 1'b1;
        #3;
        a_in = 1'b0;
        #1;
        chk(o2, 1'b1, "R7", "depth2 caught short pulse");
        chk(o3, 1'b1, "R7", "depth3 caught short pulse");
        tick();
        chk(o2, 1'b1, "R7", "depth2 after pulse edge 1");
        chk(o3, 1'b1, "R7", "depth3 after pulse edge 1");
        tick();
        chk(o2, 1'b0, "R7", "depth2 after pulse edge 2");
        chk(o3, 1'b1, "R7", "depth3 after pulse edge 2");
        tick();
        chk(o3, 1'b0, "R7", "depth3 after pulse edge 3");
    endtask

    task automatic t_short_pulse_low();
        n_in = 1'b0;
        #3;
        n_in = 1'b1;
        #1;
        chk(on, 1'b1, "R7", "active-low caught short pulse");
        tick();
        chk(on, 1'b1, "R7", "active-low after pulse edge 1");
        tick();
        chk(on, 1'b0, "R7", "active-low after pulse edge 2");
    endtask

    initial begin
        t_power_on();
        t_quiet();
        t_rise_high();
        t_quiet();
        t_fall_low();
        t_short_pulse();
        t_short_pulse_low();
        t_quiet();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule